// File: doc/BRIEF.md
# PCI Configuration Access Router

This block is the configuration-space front end of a single PCI bus. A CPU issues reads and writes at a 16-bit offset inside a configuration window. The block splits the offset into a device number, a function number and a register byte offset. It then either answers the access itself or passes it to one of a small set of attached device register ports. The bus number is always zero.

The block answers three kinds of access on its own. An identity read of a present function is built from the vendor and product IDs that the function advertises. An access to an empty device/function slot gets the fixed "no device" answer. The third kind goes to the built-in host-bridge function, which holds two base address registers. The first of these must stay at zero, and any other value raises a sticky error. The second may be written only once, and its first write opens a byte-swapped address window of fixed size that maps to target address zero. The window's base, size and enable are outputs of the block.

The CPU side uses a valid/ready handshake and never stalls. Every accepted request is answered one cycle later with a registered response.

Top module: `pci_cfg_router`

## Requirements
- R1: The device number is taken from `req_addr[15:12]`, the function number from `req_addr[10:8]` and the register offset from `req_addr[7:0]`. Bit 11 has no effect. A slot answers when its configured `{device,function}` matches.
- R2: `req_ready` is always 1. `rsp_valid` is 1 in exactly the cycle after each cycle with `req_valid` high. For a write, `rsp_rdata` is 0.
- R3: If no present function matches, a read of register 0x00 returns 0xFFFFFFFF and a read of any other register returns 0. A write changes nothing, and no `dev_sel` bit is raised.
- R4: For a present slot, a read of register 0x00 returns `{product_id, vendor_id}`, with the product ID in bits 31:16. `dev_sel` stays low for that read.
- R5: Any other read, and every write, to a present slot raises exactly that slot's `dev_sel` bit in the request cycle, with `dev_we`, `dev_reg` and `dev_wdata` valid. Read data is taken from that slot's `dev_rdata` and returned in the next cycle.
- R6: A slot with `dev_can_wr` low gets no `dev_sel` on a write. A slot with `dev_can_rd` low gets no `dev_sel` on a read, and the read returns 0.
- R7: The bridge sits at device 15, function 0. Its identity read returns 0x401310EE. The bridge takes priority over any slot configured at the same address, and that slot is never selected.
- R8: Bridge register 0x10 is read/write. Writing a nonzero value stores it and sets `bar0_err`, which stays set until reset.
- R9: Bridge register 0x14 accepts a write only while its value is 0. Such a write stores the value and sets `swap_en`. `swap_base` shows the stored value and `swap_len` is 0x10000000. Writes made after the value becomes nonzero are dropped.
- R10: The other bridge registers read as 0 and ignore writes.
- R11: After reset, both bridge base registers, `swap_en`, `bar0_err` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Offset inside the configuration window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| dev_sel | output | N_SLOTS | One-hot slot select, in the request cycle |
| dev_we | output | 1 | Direction for the selected slot |
| dev_reg | output | 8 | Register offset for the selected slot |
| dev_wdata | output | 32 | Write data for the selected slot |
| dev_rdata | input | N_SLOTS*32 | Read data from each slot, combinational |
| dev_present | input | N_SLOTS | The slot holds a function |
| dev_can_rd | input | N_SLOTS | The slot handles reads |
| dev_can_wr | input | N_SLOTS | The slot handles writes |
| dev_vendor_id | input | N_SLOTS*16 | Vendor ID of each slot |
| dev_product_id | input | N_SLOTS*16 | Product ID of each slot |
| bar0_err | output | 1 | Sticky: a nonzero value was written to bridge register 0x10 |
| swap_en | output | 1 | Byte-swap window armed |
| swap_base | output | 32 | Byte-swap window base |
| swap_len | output | 32 | Byte-swap window size in bytes |

## Verification
The assertions check the following on every cycle:
- the request/response timing;
- that `dev_sel` has at most one bit set, is raised only with a request, and is never raised for an identity read or a bridge access;
- the bridge's identity value;
- the stickiness of `bar0_err` and `swap_en`;
- that a captured nonzero swap base stays frozen.

Only the bench's scenarios can show what depends on the attached devices' configuration: slot read data, ID synthesis from the per-slot IDs, the handler-missing cases, bit 11 being ignored, and that writes to empty slots leave no trace.

// File: rtl/pci_cfg_pkg.sv
// Shared constants and types for the configuration access router.
// Assumes a 16-bit window offset and 32-bit configuration data.
package pci_cfg_pkg;

    localparam int CFG_AW = 16;
    localparam int CFG_DW = 32;
    localparam int DEVFN_W = 7;

    localparam logic [7:0] REG_IDENT = 8'h00;
    localparam logic [7:0] REG_BASE0 = 8'h10;
    localparam logic [7:0] REG_BASE1 = 8'h14;

    localparam logic [CFG_DW-1:0] NO_DEVICE = '1;

    typedef struct packed {
        logic [3:0] dev;
        logic [2:0] fn;
        logic [7:0] regno;
    } cfg_addr_t;

    // Split a window offset into device, function and register fields.
    function automatic cfg_addr_t split_addr(input logic [CFG_AW-1:0] a);
        cfg_addr_t r;
        r.dev   = a[15:12];
        r.fn    = a[10:8];
        r.regno = a[7:0];
        return r;
    endfunction

endpackage

// File: rtl/pci_cfg_decode.sv
// Address decoder: splits the offset and finds the responding target.
// The bridge address masks every slot. Among slots, the lowest index
// wins if two are configured at the same device/function.
module pci_cfg_decode
    import pci_cfg_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter logic [N_SLOTS*DEVFN_W-1:0] SLOT_DEVFN = '0,
    parameter logic [3:0] BRIDGE_DEV = 4'd15,
    parameter logic [2:0] BRIDGE_FN  = 3'd0
) (
    input  logic [CFG_AW-1:0]  addr,
    output cfg_addr_t          fields,
    output logic               bridge_hit,
    output logic [N_SLOTS-1:0] slot_hit
);

    logic [N_SLOTS-1:0] raw_hit;
    logic               unused_bit11;

    assign unused_bit11 = addr[11];

    // Field split of the incoming offset.
    assign fields = split_addr(addr);

    // Bridge match.
    assign bridge_hit = (fields.dev == BRIDGE_DEV) && (fields.fn == BRIDGE_FN);

    // Per-slot raw address comparison.
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_match
        assign raw_hit[i] = ({fields.dev, fields.fn} == SLOT_DEVFN[i*DEVFN_W +: DEVFN_W]);
    end

    // Priority resolution: bridge first, then lowest slot index.
    always_comb begin
        logic taken;
        taken    = bridge_hit;
        slot_hit = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (!taken && raw_hit[i]) begin
                slot_hit[i] = 1'b1;
                taken       = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pci_cfg_bridge.sv
// Built-in host-bridge function registers. Base 0 is read/write and
// flags a sticky error if it is given a nonzero value. Base 1 is write-once:
// it accepts a write only while zero, and that write arms the swap window.
module pci_cfg_bridge
    import pci_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        regno,
    input  logic [CFG_DW-1:0] wdata,
    output logic [CFG_DW-1:0] rdata,
    output logic              bar0_err,
    output logic              swap_en,
    output logic [CFG_DW-1:0] swap_base
);

    logic [CFG_DW-1:0] base0_q;
    logic [CFG_DW-1:0] base1_q;

    // Register updates on bridge writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base0_q  <= '0;
            base1_q  <= '0;
            bar0_err <= 1'b0;
            swap_en  <= 1'b0;
        end else if (wr_en) begin
            case (regno)
                REG_BASE0: begin
                    base0_q <= wdata;
                    if (wdata != '0) bar0_err <= 1'b1;
                end
                REG_BASE1: begin
                    if (base1_q == '0) begin
                        base1_q <= wdata;
                        swap_en <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Read-side register selection.
    always_comb begin
        case (regno)
            REG_BASE0: rdata = base0_q;
            REG_BASE1: rdata = base1_q;
            default:   rdata = '0;
        endcase
    end

    assign swap_base = base1_q;

endmodule

// File: rtl/pci_cfg_resp.sv
// Response builder: forms the read value for the accepted request and
// registers it with a one-cycle valid. Assumes slot_live is one-hot or zero.
module pci_cfg_resp
    import pci_cfg_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter logic [15:0] BRIDGE_VENDOR  = 16'h10EE,
    parameter logic [15:0] BRIDGE_PRODUCT = 16'h4013
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc,
    input  logic                      we,
    input  logic                      is_ident,
    input  logic                      bridge_hit,
    input  logic [CFG_DW-1:0]         bridge_rdata,
    input  logic [N_SLOTS-1:0]        slot_live,
    input  logic [N_SLOTS-1:0]        can_rd,
    input  logic [N_SLOTS*CFG_DW-1:0] slot_rdata,
    input  logic [N_SLOTS*16-1:0]     vendor_id,
    input  logic [N_SLOTS*16-1:0]     product_id,
    output logic                      rsp_valid,
    output logic [CFG_DW-1:0]         rsp_rdata
);

    logic [CFG_DW-1:0] slot_val;
    logic [CFG_DW-1:0] next_val;

    // OR-combine the value of the single live slot.
    always_comb begin
        slot_val = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (slot_live[i]) begin
                if (is_ident)
                    slot_val = slot_val | {product_id[i*16 +: 16], vendor_id[i*16 +: 16]};
                else if (can_rd[i])
                    slot_val = slot_val | slot_rdata[i*CFG_DW +: CFG_DW];
            end
        end
    end

    // Choose among the bridge, a slot and the empty-slot answer.
    always_comb begin
        if (we)
            next_val = '0;
        else if (bridge_hit)
            next_val = is_ident ? {BRIDGE_PRODUCT, BRIDGE_VENDOR} : bridge_rdata;
        else if (|slot_live)
            next_val = slot_val;
        else
            next_val = is_ident ? NO_DEVICE : '0;
    end

    // Registered response stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc;
            rsp_rdata <= acc ? next_val : '0;
        end
    end

endmodule

// File: rtl/pci_cfg_router.sv
// Top level of the configuration access router. It accepts one request
// per cycle, drives the slot register port in the same cycle and answers
// in the next one. Assumes the attached slots return read data combinationally.
module pci_cfg_router
    import pci_cfg_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter logic [N_SLOTS*DEVFN_W-1:0] SLOT_DEVFN = {7'h10, 7'h09, 7'h08, 7'h00},
    parameter logic [3:0]  BRIDGE_DEV     = 4'd15,
    parameter logic [2:0]  BRIDGE_FN      = 3'd0,
    parameter logic [15:0] BRIDGE_VENDOR  = 16'h10EE,
    parameter logic [15:0] BRIDGE_PRODUCT = 16'h4013,
    parameter logic [31:0] SWAP_SIZE      = 32'h1000_0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_we,
    input  logic [15:0]               req_addr,
    input  logic [31:0]               req_wdata,
    output logic                      rsp_valid,
    output logic [31:0]               rsp_rdata,
    output logic [N_SLOTS-1:0]        dev_sel,
    output logic                      dev_we,
    output logic [7:0]                dev_reg,
    output logic [31:0]               dev_wdata,
    input  logic [N_SLOTS*32-1:0]     dev_rdata,
    input  logic [N_SLOTS-1:0]        dev_present,
    input  logic [N_SLOTS-1:0]        dev_can_rd,
    input  logic [N_SLOTS-1:0]        dev_can_wr,
    input  logic [N_SLOTS*16-1:0]     dev_vendor_id,
    input  logic [N_SLOTS*16-1:0]     dev_product_id,
    output logic                      bar0_err,
    output logic                      swap_en,
    output logic [31:0]               swap_base,
    output logic [31:0]               swap_len
);

    cfg_addr_t          fields;
    logic               bridge_hit;
    logic [N_SLOTS-1:0] slot_hit;
    logic [N_SLOTS-1:0] slot_live;
    logic [N_SLOTS-1:0] handler_ok;
    logic               is_ident;
    logic               acc;
    logic [31:0]        bridge_rdata;

    // Never stalls: every valid request is accepted.
    assign req_ready = 1'b1;
    assign acc       = req_valid;
    assign swap_len  = SWAP_SIZE;

    pci_cfg_decode #(
        .N_SLOTS    (N_SLOTS),
        .SLOT_DEVFN (SLOT_DEVFN),
        .BRIDGE_DEV (BRIDGE_DEV),
        .BRIDGE_FN  (BRIDGE_FN)
    ) u_decode (
        .addr       (req_addr),
        .fields     (fields),
        .bridge_hit (bridge_hit),
        .slot_hit   (slot_hit)
    );

    // Live slot = address match on a present function.
    assign slot_live = slot_hit & dev_present;
    assign is_ident  = (fields.regno == REG_IDENT);

    // Handler availability for the access direction (identity reads never forward).
    assign handler_ok = req_we ? dev_can_wr : (is_ident ? '0 : dev_can_rd);

    // Slot register port request.
    assign dev_sel   = acc ? (slot_live & handler_ok) : '0;
    assign dev_we    = req_we;
    assign dev_reg   = fields.regno;
    assign dev_wdata = req_wdata;

    pci_cfg_bridge u_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc && req_we && bridge_hit),
        .regno     (fields.regno),
        .wdata     (req_wdata),
        .rdata     (bridge_rdata),
        .bar0_err  (bar0_err),
        .swap_en   (swap_en),
        .swap_base (swap_base)
    );

    pci_cfg_resp #(
        .N_SLOTS        (N_SLOTS),
        .BRIDGE_VENDOR  (BRIDGE_VENDOR),
        .BRIDGE_PRODUCT (BRIDGE_PRODUCT)
    ) u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc          (acc),
        .we           (req_we),
        .is_ident     (is_ident),
        .bridge_hit   (bridge_hit),
        .bridge_rdata (bridge_rdata),
        .slot_live    (slot_live),
        .can_rd       (dev_can_rd),
        .slot_rdata   (dev_rdata),
        .vendor_id    (dev_vendor_id),
        .product_id   (dev_product_id),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata)
    );

endmodule

// File: rtl/pci_cfg_router_chk.sv
// Property checker for the configuration access router, bound to the top.
// Observes ports only.
module pci_cfg_router_chk #(
    parameter int N_SLOTS = 4,
    parameter logic [3:0]  BRIDGE_DEV     = 4'd15,
    parameter logic [2:0]  BRIDGE_FN      = 3'd0,
    parameter logic [15:0] BRIDGE_VENDOR  = 16'h10EE,
    parameter logic [15:0] BRIDGE_PRODUCT = 16'h4013
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_we,
    input logic [15:0]        req_addr,
    input logic [31:0]        req_wdata,
    input logic               rsp_valid,
    input logic [31:0]        rsp_rdata,
    input logic [N_SLOTS-1:0] dev_sel,
    input logic               bar0_err,
    input logic               swap_en,
    input logic [31:0]        swap_base
);

    logic at_bridge;
    assign at_bridge = (req_addr[15:12] == BRIDGE_DEV) && (req_addr[10:8] == BRIDGE_FN);

    // Response one cycle after a request (R2)
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // At most one slot, and only with a request (R5)
    assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel));
    assert_sel_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_sel) |-> req_valid);

    // Identity reads are never forwarded (R4)
    assert_ident_not_forwarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we && req_addr[7:0] == 8'h00) |-> (dev_sel == '0));

    // Bridge identity and priority over slots (R7)
    assert_bridge_ident_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we && at_bridge && req_addr[7:0] == 8'h00)
        |=> (rsp_rdata == {BRIDGE_PRODUCT, BRIDGE_VENDOR}));
    assert_bridge_masks_slots_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && at_bridge) |-> (dev_sel == '0));

    // Nonzero base 0 write raises a sticky error (R8)
    assert_base0_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && at_bridge && req_addr[7:0] == 8'h10 && req_wdata != '0)
        |=> bar0_err);
    assert_base0_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bar0_err |=> bar0_err);

    // Swap window is sticky and a nonzero base is frozen (R9)
    assert_swap_en_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en |=> swap_en);
    assert_swap_base_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_base != '0) |=> $stable(swap_base));

endmodule

bind pci_cfg_router pci_cfg_router_chk #(
    .N_SLOTS        (N_SLOTS),
    .BRIDGE_DEV     (BRIDGE_DEV),
    .BRIDGE_FN      (BRIDGE_FN),
    .BRIDGE_VENDOR  (BRIDGE_VENDOR),
    .BRIDGE_PRODUCT (BRIDGE_PRODUCT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .dev_sel   (dev_sel),
    .bar0_err  (bar0_err),
    .swap_en   (swap_en),
    .swap_base (swap_base)
);

// File: tb/tb_pci_cfg_router.sv
// Bench: a vector table walked by one loop, then directed tests.
module tb_pci_cfg_router;

    localparam int N = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [15:0]       req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [N-1:0]      dev_sel;
    logic              dev_we;
    logic [7:0]        dev_reg;
    logic [31:0]       dev_wdata;
    logic [N*32-1:0]   dev_rdata;
    logic [N-1:0]      dev_present = 4'b1111;
    logic [N-1:0]      dev_can_rd  = 4'b1101;
    logic [N-1:0]      dev_can_wr  = 4'b1011;
    logic [N*16-1:0]   dev_vendor_id;
    logic [N*16-1:0]   dev_product_id;
    logic              bar0_err;
    logic              swap_en;
    logic [31:0]       swap_base;
    logic [31:0]       swap_len;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    int          wr_cnt  [N] = '{0, 0, 0, 0};
    logic [7:0]  wr_reg  [N] = '{8'h0, 8'h0, 8'h0, 8'h0};
    logic [31:0] wr_data [N] = '{32'h0, 32'h0, 32'h0, 32'h0};

    always #4 clk = ~clk;   // 125 MHz

    // Slot 3 sits on the bridge address to show the bridge's priority.
    pci_cfg_router #(
        .N_SLOTS    (N),
        .SLOT_DEVFN ({7'h78, 7'h09, 7'h08, 7'h00})
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dev_sel(dev_sel),
        .dev_we(dev_we), .dev_reg(dev_reg), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .dev_present(dev_present), .dev_can_rd(dev_can_rd),
        .dev_can_wr(dev_can_wr), .dev_vendor_id(dev_vendor_id),
        .dev_product_id(dev_product_id), .bar0_err(bar0_err), .swap_en(swap_en),
        .swap_base(swap_base), .swap_len(swap_len)
    );

    // Slot models: read data and IDs derived from the slot index.
    for (genvar i = 0; i < N; i++) begin : g_slot
        assign dev_rdata[i*32 +: 32]      = 32'hD000_0000 | (32'(i) << 24) | {24'h0, dev_reg};
        assign dev_vendor_id[i*16 +: 16]  = 16'h1000 + 16'(i);
        assign dev_product_id[i*16 +: 16] = 16'h2000 + 16'(i);
    end

    // Slot write recorder.
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst_n && dev_sel[i] && dev_we) begin
                wr_cnt[i]  <= wr_cnt[i] + 1;
                wr_reg[i]  <= dev_reg;
                wr_data[i] <= dev_wdata;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One request: drive at negedge, capture select, capture response after the edge.
    task automatic access(input logic we, input logic [15:0] addr, input logic [31:0] wd,
                          output logic [N-1:0] sel, output logic [31:0] rd, output logic rv);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
        #1 sel = dev_sel;
        @(posedge clk);
        #1 rd = rsp_rdata; rv = rsp_valid;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    // {we, addr, wdata, expected rdata, expected dev_sel}
    localparam int NV = 15;
    localparam logic [84:0] VEC [NV] = '{
        {1'b0, 16'h0000, 32'h0, 32'h2000_1000, 4'b0000}, // R4 slot0 identity
        {1'b0, 16'h0008, 32'h0, 32'hD000_0008, 4'b0001}, // R5 slot0 forwarded read
        {1'b0, 16'h103C, 32'h0, 32'h0000_0000, 4'b0000}, // R6 slot1 no read handler
        {1'b0, 16'h1104, 32'h0, 32'hD200_0004, 4'b0100}, // R1 slot2 on function 1
        {1'b0, 16'h2000, 32'h0, 32'hFFFF_FFFF, 4'b0000}, // R3 empty identity
        {1'b0, 16'h2010, 32'h0, 32'h0000_0000, 4'b0000}, // R3 empty other reg
        {1'b0, 16'h5000, 32'h0, 32'hFFFF_FFFF, 4'b0000}, // R3 empty device 5
        {1'b0, 16'h0800, 32'h0, 32'h2000_1000, 4'b0000}, // R1 bit 11 ignored
        {1'b0, 16'hF000, 32'h0, 32'h4013_10EE, 4'b0000}, // R7 bridge identity
        {1'b0, 16'hF020, 32'h0, 32'h0000_0000, 4'b0000}, // R10 bridge other reg
        {1'b0, 16'hF100, 32'h0, 32'hFFFF_FFFF, 4'b0000}, // R1 dev15 fn1 empty
        {1'b1, 16'h0044, 32'h1234_5678, 32'h0, 4'b0001}, // R5 slot0 write
        {1'b1, 16'h1110, 32'hCAFE_0001, 32'h0, 4'b0000}, // R6 slot2 no write handler
        {1'b1, 16'h7010, 32'hCAFE_0002, 32'h0, 4'b0000}, // R3 write to empty slot
        {1'b0, 16'h1000, 32'h0, 32'h2001_1001, 4'b0000}  // R4 slot1 identity
    };

    function automatic string vec_tag(input int k);
        case (k)
            0, 14:           return "R4";
            1, 11:           return "R5";
            2, 12:           return "R6";
            3, 7, 10:        return "R1";
            8:               return "R7";
            9:               return "R10";
            default:         return "R3";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] s;
        logic [31:0]  r;
        logic         v;

        repeat (3) @(posedge clk);
        #1;
        // Reset state (R11)
        chk("R11 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
        chk("R2 req_ready", {31'h0, req_ready}, 32'h1);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R11 swap_en after reset", {31'h0, swap_en}, 32'h0);
        chk("R11 bar0_err after reset", {31'h0, bar0_err}, 32'h0);
        chk("R11 swap_base after reset", swap_base, 32'h0);
        chk("R2 no response without request", {31'h0, rsp_valid}, 32'h0);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            logic [84:0] t;
            t = VEC[k];
            access(t[84], t[83:68], t[67:36], s, r, v);
            chk({vec_tag(k), " rsp_valid"}, {31'h0, v}, 32'h1);
            chk({vec_tag(k), " rdata"}, r, t[35:4]);
            chk({vec_tag(k), " dev_sel"}, {28'h0, s}, {28'h0, t[3:0]});
        end

        // Write contents seen on the slot port (R5), dropped writes (R6, R3)
        chk("R5 slot0 write count", 32'(wr_cnt[0]), 32'd1);
        chk("R5 slot0 write reg", {24'h0, wr_reg[0]}, 32'h44);
        chk("R5 slot0 write data", wr_data[0], 32'h1234_5678);
        chk("R6 slot2 write count", 32'(wr_cnt[2]), 32'd0);
        chk("R3 slot1 write count", 32'(wr_cnt[1]), 32'd0);

        // BAR0 (R8)
        access(1'b1, 16'hF010, 32'h0, s, r, v);
        chk("R8 zero write no error", {31'h0, bar0_err}, 32'h0);
        access(1'b1, 16'hF010, 32'hABCD_0000, s, r, v);
        chk("R8 nonzero write error", {31'h0, bar0_err}, 32'h1);
        access(1'b0, 16'hF010, 32'h0, s, r, v);
        chk("R8 base0 readback", r, 32'hABCD_0000);
        access(1'b1, 16'hF010, 32'h0, s, r, v);
        chk("R8 error sticky", {31'h0, bar0_err}, 32'h1);
        access(1'b0, 16'hF010, 32'h0, s, r, v);
        chk("R8 base0 cleared", r, 32'h0);

        // BAR1 write-once (R9)
        chk("R9 window idle", {31'h0, swap_en}, 32'h0);
        access(1'b1, 16'hF014, 32'h3000_0000, s, r, v);
        chk("R9 window armed", {31'h0, swap_en}, 32'h1);
        chk("R9 window base", swap_base, 32'h3000_0000);
        chk("R9 window size", swap_len, 32'h1000_0000);
        access(1'b1, 16'hF014, 32'h5000_0000, s, r, v);
        chk("R9 second write dropped", swap_base, 32'h3000_0000);
        access(1'b0, 16'hF014, 32'h0, s, r, v);
        chk("R9 base1 readback", r, 32'h3000_0000);

        // Other bridge register ignores writes (R10), slot3 shadowed (R7)
        access(1'b1, 16'hF020, 32'hFFFF_FFFF, s, r, v);
        chk("R7 bridge write not forwarded", {28'h0, s}, 32'h0);
        access(1'b0, 16'hF020, 32'h0, s, r, v);
        chk("R10 other reg still zero", r, 32'h0);
        chk("R7 shadowed slot never written", 32'(wr_cnt[3]), 32'd0);

        // Reset clears bridge state (R11)
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R11 swap_en cleared", {31'h0, swap_en}, 32'h0);
        chk("R11 bar0_err cleared", {31'h0, bar0_err}, 32'h0);
        chk("R11 swap_base cleared", swap_base, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        access(1'b0, 16'hF010, 32'h0, s, r, v);
        chk("R11 base0 cleared", r, 32'h0);
        access(1'b1, 16'hF014, 32'h0, s, r, v);
        chk("R9 zero write arms window", {31'h0, swap_en}, 32'h1);
        access(1'b1, 16'hF014, 32'h0600_0000, s, r, v);
        chk("R9 capture while still zero", swap_base, 32'h0600_0000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule